// File: doc/BRIEF.md
# Link Power Watchdog and Link-On Controller

This block sits in a serial bus PHY, between the link-power status line from the link-layer controller and the two-way pin that carries the contender strap and the link-on signal. It brings the asynchronous link-power level into the reference clock domain and counts how long that level stays low. A brief drop makes it reset the PHY-link interface. A long drop makes it disable that interface until the link reports power again.

While the link is unpowered, some events must wake it: a link-on packet addressed to this node, or certain interrupt register bits. For these events the block drives a free-running link-on clock on the pin. The clock is the reference divided by four. It keeps running until the link reports power. A bus reset stops the clock only when the sole reason for it was a link-on packet. During hardware reset the pin is an input, and its level is latched as the node's bus-manager contender strap. After reset the block drives the pin, which stays low when no link-on clock is needed.

Top module: `lps_linkon_ctrl`

## Requirements
- R1: If the synchronised link-power level is low for N reference cycles with 30 <= N < 615, `if_reset_o` is high for exactly one cycle after the level returns high. For N < 30 no pulse occurs.
- R2: If the level stays low for 615 or more cycles, `if_enable_o` goes low while it stays low, and no reset pulse follows when it returns. For N = 614, `if_enable_o` never drops.
- R3: Within 8 cycles after `lps_i` goes high, `if_enable_o` is high again.
- R4: A one-cycle `linkon_pkt_i` strobe while the interface is disabled starts the link-on clock on `pin_out_o`, with a period of 4 cycles (2 high, 2 low). A strobe while the interface is enabled has no effect.
- R5: `port_event_i` = 1 while the link-power level is low starts the link-on clock.
- R6: Any of `timeout_i`, `pwr_fail_i` or `loop_i` at 1 together with `resume_int_i` = 1 starts the link-on clock. Without `resume_int_i` these bits start nothing.
- R7: Once started, the link-on clock runs on after its cause clears, and it stops within a few cycles of `lps_i` going high.
- R8: `bus_reset_i` stops the link-on clock when a link-on packet was its only cause. It has no effect once a register bit has also been a cause.
- R9: A register wake condition present while the link-power level is high produces no output, and it starts the link-on clock once the level goes low.
- R10: While `rst_n` is low, `pin_oe_o` is 0 and `contender_o` takes the level of `pin_in_i`. After reset, `pin_oe_o` is 1, `contender_o` holds the value latched during reset, and `pin_out_o` is 0 while no wake is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Hardware reset, active low |
| lps_i | input | 1 | Link power status from the link layer, asynchronous, high = powered |
| linkon_pkt_i | input | 1 | One-cycle strobe: a link-on packet for this node was received |
| bus_reset_i | input | 1 | One-cycle strobe: a bus reset occurred |
| port_event_i | input | 1 | Port event register bit |
| timeout_i | input | 1 | Timeout register bit |
| pwr_fail_i | input | 1 | Power fail register bit |
| loop_i | input | 1 | Loop register bit |
| resume_int_i | input | 1 | Resume interrupt enable register bit |
| pin_in_i | input | 1 | Level read from the contender/link-on pin |
| pin_out_o | output | 1 | Level driven onto the pin (link-on clock) |
| pin_oe_o | output | 1 | Pin output enable, 0 during hardware reset |
| contender_o | output | 1 | Bus-manager contender strap latched during reset |
| if_reset_o | output | 1 | One-cycle PHY-link interface reset request |
| if_enable_o | output | 1 | PHY-link interface enable level |

## Verification
The assertions watch, on every cycle, the invariants of both state machines:
- the interface reset is a single-cycle pulse;
- no pulse follows a disable;
- the interface is re-enabled once power is seen again;
- the loss counter stays bounded;
- a register wake condition activates the link-on clock;
- the clock stays active until power returns or a packet-only bus reset occurs;
- a register cause survives a bus reset.

Only the bench scenarios can show the exact loss-window limits (29/30 and 614/615 cycles) and the real toggle rate on the pin. The same holds for deferred activation, the ignored packet strobe while the link is powered, and the strap capture at reset. These depend on durations and on sequences across the synchroniser.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned SHORT_CYC_DEF   = 30;
    localparam int unsigned LONG_CYC_DEF    = 615;
    localparam int unsigned LINKON_DIV_DEF  = 4;

    // Register-driven wake: port event, or an interrupt cause with resume enabled
    function automatic logic reg_wake(input logic port_ev,
                                      input logic tmo,
                                      input logic pfail,
                                      input logic lp,
                                      input logic res_int);
        return port_ev | ((tmo | pfail | lp) & res_int);
    endfunction

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lps_loss_timer.sv
module lps_loss_timer #(
    parameter int unsigned SHORT_CYC = 30,
    parameter int unsigned LONG_CYC  = 615
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_s_i,
    output logic if_reset_o,
    output logic disabled_o
);
    localparam int unsigned CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst_pulse;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rst_pulse = 1'b0;
        if (lps_s_i) begin
            st_d.cnt       = '0;
            st_d.rst_pulse = (st_q.cnt >= SHORT_V) && (st_q.cnt < LONG_V);
        end else if (st_q.cnt != LONG_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign if_reset_o = st_q.rst_pulse;
    assign disabled_o = (st_q.cnt == LONG_V);

    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset_o |=> !if_reset_o);
    // R2
    no_pulse_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disabled_o |=> !if_reset_o);
    // R3
    reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lps_s_i |=> !disabled_o);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LONG_V);
endmodule

// File: rtl/lps_linkon_gen.sv
module lps_linkon_gen
    import lps_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_s_i,
    input  logic disabled_i,
    input  logic pkt_i,
    input  logic bus_reset_i,
    input  logic port_event_i,
    input  logic timeout_i,
    input  logic pwr_fail_i,
    input  logic loop_i,
    input  logic resume_int_i,
    output logic pin_o
);
    localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST_V = DW'(DIV - 1);
    localparam logic [DW-1:0] HALF_V = DW'(DIV / 2);

    typedef struct packed {
        logic          active;
        logic          pkt_only;
        logic [DW-1:0] div;
    } lon_t;

    lon_t st_d, st_q;
    logic wake;

    always_comb begin
        wake = reg_wake(port_event_i, timeout_i, pwr_fail_i, loop_i, resume_int_i);
        st_d = st_q;
        if (lps_s_i) begin
            st_d.active   = 1'b0;
            st_d.pkt_only = 1'b0;
        end else if (wake) begin
            st_d.active   = 1'b1;
            st_d.pkt_only = 1'b0;
        end else if (pkt_i && disabled_i) begin
            st_d.active   = 1'b1;
            st_d.pkt_only = !st_q.active || st_q.pkt_only;
        end else if (bus_reset_i && st_q.active && st_q.pkt_only) begin
            st_d.active   = 1'b0;
            st_d.pkt_only = 1'b0;
        end
        if (st_q.active) st_d.div = (st_q.div == LAST_V) ? '0 : st_q.div + 1'b1;
        else             st_d.div = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = st_q.active && (st_q.div >= HALF_V);

    // R7
    stop_on_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lps_s_i |=> !pin_o);
    // R7
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !lps_s_i && !bus_reset_i |=> st_q.active);
    // R5
    wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake && !lps_s_i |=> st_q.active);
    // R8
    pkt_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i && st_q.pkt_only && !wake && !pkt_i && !lps_s_i |=> !st_q.active);
    // R8
    reg_cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !st_q.pkt_only && !lps_s_i |=> st_q.active);
endmodule

// File: rtl/lps_linkon_ctrl.sv
module lps_linkon_ctrl
    import lps_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned SHORT_CYC   = SHORT_CYC_DEF,
    parameter int unsigned LONG_CYC    = LONG_CYC_DEF,
    parameter int unsigned LINKON_DIV  = LINKON_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_i,
    input  logic linkon_pkt_i,
    input  logic bus_reset_i,
    input  logic port_event_i,
    input  logic timeout_i,
    input  logic pwr_fail_i,
    input  logic loop_i,
    input  logic resume_int_i,
    input  logic pin_in_i,
    output logic pin_out_o,
    output logic pin_oe_o,
    output logic contender_o,
    output logic if_reset_o,
    output logic if_enable_o
);
    logic lps_s;
    logic disabled;
    logic oe_d, oe_q;
    logic cont_d, cont_q;

    lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(lps_i), .q_o(lps_s)
    );

    lps_loss_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .lps_s_i(lps_s),
        .if_reset_o(if_reset_o), .disabled_o(disabled)
    );

    lps_linkon_gen #(.DIV(LINKON_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n), .lps_s_i(lps_s), .disabled_i(disabled),
        .pkt_i(linkon_pkt_i), .bus_reset_i(bus_reset_i),
        .port_event_i(port_event_i), .timeout_i(timeout_i),
        .pwr_fail_i(pwr_fail_i), .loop_i(loop_i),
        .resume_int_i(resume_int_i), .pin_o(pin_out_o)
    );

    // Strap capture while reset is held; pin becomes an output afterwards
    always_comb begin
        oe_d   = 1'b1;
        cont_d = rst_n ? cont_q : pin_in_i;
    end

    always_ff @(posedge clk) begin
        cont_q <= cont_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign pin_oe_o    = oe_q;
    assign contender_o = cont_q;
    assign if_enable_o = !disabled;
endmodule

// File: tb/lps_linkon_ctrl_bench.sv
module lps_linkon_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_i = 1'b1, linkon_pkt_i = 1'b0, bus_reset_i = 1'b0;
    logic port_event_i = 1'b0, timeout_i = 1'b0, pwr_fail_i = 1'b0;
    logic loop_i = 1'b0, resume_int_i = 1'b0, pin_in_i = 1'b1;
    logic pin_out_o, pin_oe_o, contender_o, if_reset_o, if_enable_o;

    int tests = 0, fails = 0;
    int pulse_cnt = 0, rise_cnt = 0;
    bit dis_seen = 0, prev_pin = 0, done = 0;

    always #5 clk = ~clk;

    lps_linkon_ctrl u_lps_linkon_ctrl (.*);

    always @(negedge clk) begin
        if (if_reset_o) pulse_cnt++;
        if (!if_enable_o) dis_seen = 1;
        if (pin_out_o && !prev_pin) rise_cnt++;
        prev_pin = pin_out_o;
    end

    function automatic int exp_pulses(input int n);
        return (n >= 30 && n < 615) ? 1 : 0;
    endfunction
    function automatic bit exp_dis(input int n);
        return n >= 615;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); #1;
        pulse_cnt = 0; rise_cnt = 0; dis_seen = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic loss(input int n);
        clear_mon();
        @(negedge clk) lps_i = 1'b0;
        repeat (n) @(negedge clk);
        lps_i = 1'b1;
        cycles(10);
    endtask

    task automatic measure_rises(input int n, output int r);
        clear_mon();
        cycles(n);
        r = rise_cnt;
    endtask

    task automatic strobe_pkt();
        @(negedge clk) linkon_pkt_i = 1'b1;
        @(negedge clk) linkon_pkt_i = 1'b0;
    endtask

    task automatic strobe_bus_reset();
        @(negedge clk) bus_reset_i = 1'b1;
        @(negedge clk) bus_reset_i = 1'b0;
    endtask

    task automatic idle_all();
        port_event_i = 0; timeout_i = 0; pwr_fail_i = 0; loop_i = 0; resume_int_i = 0;
        lps_i = 1'b1;
        cycles(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r;
        int sizes[6] = '{29, 30, 614, 615, 5, 700};
        void'($urandom(32'd1337));
        // R10: reset state
        cycles(4);
        chk(pin_oe_o == 0, "R10 oe during reset", pin_oe_o, 0);
        chk(contender_o == 1, "R10 strap capture", contender_o, 1);
        @(negedge clk) rst_n = 1'b1;
        pin_in_i = 1'b0;
        cycles(6);
        chk(pin_oe_o == 1, "R10 oe after reset", pin_oe_o, 1);
        chk(contender_o == 1, "R10 strap held", contender_o, 1);
        chk(pin_out_o == 0, "R10 pin idle low", pin_out_o, 0);

        // R1 / R2 directed window edges
        foreach (sizes[i]) begin
            loss(sizes[i]);
            chk(pulse_cnt == exp_pulses(sizes[i]), $sformatf("R1 pulses n=%0d", sizes[i]),
                pulse_cnt, exp_pulses(sizes[i]));
            chk(dis_seen == exp_dis(sizes[i]), $sformatf("R2 disable n=%0d", sizes[i]),
                dis_seen, exp_dis(sizes[i]));
            chk(if_enable_o == 1, "R3 re-enabled", if_enable_o, 1);
        end

        // R1 / R2 random durations
        for (int k = 0; k < 20; k++) begin
            int n = $urandom_range(0, 700);
            loss(n);
            chk(pulse_cnt == exp_pulses(n), $sformatf("R1 rnd n=%0d", n), pulse_cnt, exp_pulses(n));
            chk(dis_seen == exp_dis(n), $sformatf("R2 rnd n=%0d", n), dis_seen, exp_dis(n));
        end

        // R4: packet ignored while enabled
        strobe_pkt();
        measure_rises(30, r);
        chk(r == 0, "R4 packet ignored when enabled", r, 0);

        // R4: packet while disabled starts link-on clock
        @(negedge clk) lps_i = 1'b0;
        cycles(650);
        chk(if_enable_o == 0, "R2 disabled before packet", if_enable_o, 0);
        strobe_pkt();
        cycles(3);
        measure_rises(40, r);
        chk(r >= 9 && r <= 11, "R4 toggle rate", r, 10);
        // R8: bus reset clears packet-only cause
        strobe_bus_reset();
        cycles(3);
        measure_rises(20, r);
        chk(r == 0, "R8 bus reset stops packet wake", r, 0);
        idle_all();
        chk(if_enable_o == 1, "R3 enabled after return", if_enable_o, 1);

        // R5 + R7 + R8: port event cause is sticky and survives bus reset
        @(negedge clk) lps_i = 1'b0; port_event_i = 1'b1;
        cycles(5);
        measure_rises(40, r);
        chk(r >= 9 && r <= 11, "R5 port event toggles", r, 10);
        port_event_i = 1'b0;
        strobe_bus_reset();
        measure_rises(40, r);
        chk(r >= 9 && r <= 11, "R8 register cause survives bus reset", r, 10);
        @(negedge clk) lps_i = 1'b1;
        cycles(6);
        measure_rises(20, r);
        chk(r == 0 && pin_out_o == 0, "R7 stops on power", r, 0);

        // R6: each interrupt cause needs resume enable
        for (int b = 0; b < 3; b++) begin
            idle_all();
            @(negedge clk) lps_i = 1'b0;
            timeout_i = (b == 0); pwr_fail_i = (b == 1); loop_i = (b == 2);
            cycles(5);
            measure_rises(30, r);
            chk(r == 0, $sformatf("R6 no resume bit=%0d", b), r, 0);
            resume_int_i = 1'b1;
            cycles(3);
            measure_rises(40, r);
            chk(r >= 9 && r <= 11, $sformatf("R6 with resume bit=%0d", b), r, 10);
        end
        idle_all();

        // R9: wake held pending while powered
        port_event_i = 1'b1;
        measure_rises(30, r);
        chk(r == 0, "R9 pending while powered", r, 0);
        @(negedge clk) lps_i = 1'b0;
        cycles(5);
        measure_rises(40, r);
        chk(r >= 9 && r <= 11, "R9 starts on power loss", r, 10);
        idle_all();
        chk(pin_out_o == 0, "R10 pin low when idle", pin_out_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule